// File: doc/BRIEF.md
# Timestamp Event Capture Unit

A free-running 32-bit time base with a small word-addressed register port. Whenever something worth timing happens, the unit writes a 64-bit record into a first-in first-out queue. The record holds the time-base value and a descriptor word that says what happened and where. Software then reads the record at the queue head and discards it with a pop write.

The unit records six kinds of events:

- a software push write;
- the counter wrapping to zero;
- the counter crossing its half-range point;
- a rising edge on one of four enabled hardware pins;
- receive and transmit strobes from an Ethernet port, each carrying a port number, a PTP message type and a sequence ID.

The unit queues at most one event per cycle. An interrupt line stays high while the queue is not empty (or the test bit is set), gated by an enable bit. Events that cannot be stored set a sticky overflow flag. Software can read that flag and clear it.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset every register reads zero except the identification word, the queue is empty, reads of the event words return zero and `irq` is low.
- R2: Control bit 0 runs the time base, which then adds 1 each clock. While bit 0 is clear the count holds and no event of any kind is queued.
- R3: Writing 1 to bit 0 at offset 0x14 copies the load-value register (offset 0x10, read/write) into the count on that edge. This takes precedence over counting, and counting resumes from the loaded value.
- R4: Writing 1 to bit 0 at offset 0x0C queues a type-0 event stamped with the count held in the cycle of the write.
- R5: Counting from 0xFFFFFFFF to 0 queues a type-1 event stamped 0x00000000. Counting from 0x7FFFFFFF to 0x80000000 queues a type-2 event stamped 0x80000000. Loads never produce either event.
- R6: A rising edge on `hw_pin[k]` (k = 0..3), with control bit 8+k set, queues one type-3 event with port field k+1, stamped with the count in the first cycle the pin is high. A pin whose enable bit is clear is ignored, and a pin held high produces no further events.
- R7: `rx_stb` queues a type-4 event and `tx_stb` a type-5 event. Each is stamped with the current count and carries the strobe's port, message type and sequence ID.
- R8: The descriptor word (offset 0x38) holds the port in bits 28:24, the type in bits 23:20, the message type in bits 19:16 and the sequence ID in bits 15:0, with bits 31:29 zero. Offset 0x34 holds the stamp. Reading either word does not remove the record.
- R9: Records leave the queue in arrival order, and the queue holds FIFO_DEPTH entries (16 by default). Writing 1 to bit 0 at offset 0x30 discards the head, and this has no effect on an empty queue. While the queue is empty, offsets 0x34 and 0x38 read zero.
- R10: An event that arrives while the queue is full is dropped; fullness is judged before a pop in the same cycle. The drop sets the sticky overflow flag, read at bit 1 of offset 0x20. Writing 1 to that bit clears the flag, and a new drop in the same cycle wins over the clear.
- R11: Bit 0 of offset 0x20 is (queue not empty) OR (control bit 1). Bit 0 of offset 0x24 is that bit ANDed with bit 0 of offset 0x28, and `irq` equals it.
- R12: When several sources fire in one cycle, only one is queued, in this priority order: wrap, half, pins 1 to 4, receive, transmit, software push. The others are lost and set the overflow flag.
- R13: Offset 0x00 reads the ID_WORD parameter. The control word (offset 0x04) reads back only bits 0, 1 and 8 to 11. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 6 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| hw_pin | input | 4 | Hardware push pins, level inputs |
| rx_stb | input | 1 | Receive timestamp strobe |
| rx_port | input | 5 | Receive port number |
| rx_msg | input | 4 | Receive PTP message type |
| rx_seq | input | 16 | Receive PTP sequence ID |
| tx_stb | input | 1 | Transmit timestamp strobe |
| tx_port | input | 5 | Transmit port number |
| tx_msg | input | 4 | Transmit PTP message type |
| tx_seq | input | 16 | Transmit PTP sequence ID |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the unit with FIFO_DEPTH set to 4 and a non-default ID_WORD. With the shallow queue, the full state, the drop, the sticky flag and the pop-on-empty case are all reached within a handful of push writes. The changed ID word shows that the identification register follows its parameter. The wrap and half-range events are reached by loading values a few counts below each boundary rather than counting through 2^31 cycles.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int TS_W    = 32;
  localparam int HW_PINS = 4;
  localparam int N_SRC   = HW_PINS + 5;

  typedef enum logic [3:0] {
    EV_SW   = 4'd0,
    EV_WRAP = 4'd1,
    EV_HALF = 4'd2,
    EV_PIN  = 4'd3,
    EV_RX   = 4'd4,
    EV_TX   = 4'd5
  } ev_kind_e;

  typedef struct packed {
    logic [31:0]     desc;
    logic [TS_W-1:0] stamp;
  } ev_rec_t;

  localparam logic [5:0] A_IDENT    = 6'h00;
  localparam logic [5:0] A_CTRL     = 6'h04;
  localparam logic [5:0] A_SWPUSH   = 6'h0C;
  localparam logic [5:0] A_LDVAL    = 6'h10;
  localparam logic [5:0] A_LDGO     = 6'h14;
  localparam logic [5:0] A_STAT_RAW = 6'h20;
  localparam logic [5:0] A_STAT_MSK = 6'h24;
  localparam logic [5:0] A_IRQ_EN   = 6'h28;
  localparam logic [5:0] A_POP      = 6'h30;
  localparam logic [5:0] A_EV_TS    = 6'h34;
  localparam logic [5:0] A_EV_DESC  = 6'h38;

  // descriptor layout: port 28:24, kind 23:20, message 19:16, sequence 15:0
  function automatic logic [31:0] pack_desc(logic [4:0] port, ev_kind_e kind,
                                            logic [3:0] msg, logic [15:0] seq);
    return {3'b000, port, kind, msg, seq};
  endfunction

  function automatic logic at_wrap(logic [TS_W-1:0] v);
    return v == {TS_W{1'b1}};
  endfunction

  function automatic logic at_half(logic [TS_W-1:0] v);
    return v == {1'b0, {(TS_W-1){1'b1}}};
  endfunction
endpackage

// File: rtl/tsc_time_base.sv
module tsc_time_base
  import tsc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            load,
  input  logic [TS_W-1:0] load_val,
  output logic [TS_W-1:0] now,
  output logic            wrap_evt,
  output logic            half_evt
);
  logic [TS_W-1:0] cnt_q;
  logic            step;

  assign step     = run && !load;
  assign wrap_evt = step && at_wrap(cnt_q);
  assign half_evt = step && at_half(cnt_q);
  assign now      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (run)  cnt_q <= cnt_q + 1'b1;
  end

  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> now == '0);
  // R5
  half_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_evt |=> (now[TS_W-1] && now[TS_W-2:0] == '0));
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(now));
  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> now == $past(load_val));
endmodule

// File: rtl/tsc_src_arb.sv
module tsc_src_arb
  import tsc_pkg::*;
(
  input  logic               en,
  input  logic               wrap_evt,
  input  logic               half_evt,
  input  logic [HW_PINS-1:0] pin_rise,
  input  logic               rx_stb,
  input  logic [4:0]         rx_port,
  input  logic [3:0]         rx_msg,
  input  logic [15:0]        rx_seq,
  input  logic               tx_stb,
  input  logic [4:0]         tx_port,
  input  logic [3:0]         tx_msg,
  input  logic [15:0]        tx_seq,
  input  logic               sw_push,
  input  logic [TS_W-1:0]    now,
  output logic               win_vld,
  output ev_rec_t            win_rec,
  output logic               collide
);
  localparam int IX_RX = 2 + HW_PINS;
  localparam int IX_TX = IX_RX + 1;
  localparam int IX_SW = IX_TX + 1;

  logic [N_SRC-1:0] req;
  ev_rec_t          cand [N_SRC];

  // index order is priority order: lowest index wins
  assign req     = {sw_push, tx_stb, rx_stb, pin_rise, half_evt, wrap_evt} & {N_SRC{en}};
  assign win_vld = |req;
  assign collide = $countones(req) > 1;

  always_comb begin
    cand[0].desc  = pack_desc(5'd0, EV_WRAP, 4'd0, 16'd0);
    cand[0].stamp = '0;
    cand[1].desc  = pack_desc(5'd0, EV_HALF, 4'd0, 16'd0);
    cand[1].stamp = {1'b1, {(TS_W-1){1'b0}}};
    for (int k = 0; k < HW_PINS; k++) begin
      cand[2+k].desc  = pack_desc(5'(k + 1), EV_PIN, 4'd0, 16'd0);
      cand[2+k].stamp = now;
    end
    cand[IX_RX].desc  = pack_desc(rx_port, EV_RX, rx_msg, rx_seq);
    cand[IX_RX].stamp = now;
    cand[IX_TX].desc  = pack_desc(tx_port, EV_TX, tx_msg, tx_seq);
    cand[IX_TX].stamp = now;
    cand[IX_SW].desc  = pack_desc(5'd0, EV_SW, 4'd0, 16'd0);
    cand[IX_SW].stamp = now;

    win_rec = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) win_rec = cand[i];
    end
  end
endmodule

// File: rtl/tsc_event_fifo.sv
module tsc_event_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         dropped
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          wr_ok, rd_ok;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = cnt == CW'(DEPTH);
  assign empty   = cnt == '0;
  assign wr_ok   = push && !full;
  assign rd_ok   = pop && !empty;
  assign dropped = push && full;
  assign head    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= bump(wp);
      if (rd_ok) rp <= bump(rp);
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dropped && !rd_ok) |=> full);
  // R9
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
  import tsc_pkg::*;
#(
  parameter int          FIFO_DEPTH = 16,
  parameter logic [31:0] ID_WORD    = 32'h4E51_0A01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [3:0]  hw_pin,
  input  logic        rx_stb,
  input  logic [4:0]  rx_port,
  input  logic [3:0]  rx_msg,
  input  logic [15:0] rx_seq,
  input  logic        tx_stb,
  input  logic [4:0]  tx_port,
  input  logic [3:0]  tx_msg,
  input  logic [15:0] tx_seq,
  output logic        irq
);
  localparam logic [31:0] CTRL_MASK = (32'((1 << HW_PINS) - 1) << 8) | 32'h3;
  localparam int          REC_W     = $bits(ev_rec_t);

  logic [31:0]        ctrl_q, ldval_q;
  logic               ie_q, ovf_q;
  logic [HW_PINS-1:0] pin_q, pin_rise;
  logic               run, test_irq;
  logic               sw_push, load_go, pop_go, ovf_clr;
  logic [TS_W-1:0]    now;
  logic               wrap_evt, half_evt;
  logic               win_vld, collide;
  ev_rec_t            win_rec, head_rec;
  logic [REC_W-1:0]   head_bits;
  logic               q_empty, q_full, q_drop;
  logic               raw_pend, irq_lvl;

  function automatic logic wr_hit(logic we, logic [5:0] a, logic [5:0] target);
    return we && (a == target);
  endfunction

  assign sw_push = wr_hit(reg_we, reg_addr, A_SWPUSH)   && reg_wdata[0];
  assign load_go = wr_hit(reg_we, reg_addr, A_LDGO)     && reg_wdata[0];
  assign pop_go  = wr_hit(reg_we, reg_addr, A_POP)      && reg_wdata[0];
  assign ovf_clr = wr_hit(reg_we, reg_addr, A_STAT_RAW) && reg_wdata[1];

  assign run      = ctrl_q[0];
  assign test_irq = ctrl_q[1];

  for (genvar k = 0; k < HW_PINS; k++) begin : g_pin
    assign pin_rise[k] = hw_pin[k] && !pin_q[k] && ctrl_q[8+k];
  end

  tsc_time_base u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .load     (load_go),
    .load_val (ldval_q),
    .now      (now),
    .wrap_evt (wrap_evt),
    .half_evt (half_evt)
  );

  tsc_src_arb u_arb (
    .en       (run),
    .wrap_evt (wrap_evt),
    .half_evt (half_evt),
    .pin_rise (pin_rise),
    .rx_stb   (rx_stb),
    .rx_port  (rx_port),
    .rx_msg   (rx_msg),
    .rx_seq   (rx_seq),
    .tx_stb   (tx_stb),
    .tx_port  (tx_port),
    .tx_msg   (tx_msg),
    .tx_seq   (tx_seq),
    .sw_push  (sw_push),
    .now      (now),
    .win_vld  (win_vld),
    .win_rec  (win_rec),
    .collide  (collide)
  );

  tsc_event_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (win_vld),
    .din     (win_rec),
    .pop     (pop_go),
    .head    (head_bits),
    .empty   (q_empty),
    .full    (q_full),
    .dropped (q_drop)
  );

  assign head_rec = head_bits;
  assign raw_pend = !q_empty || test_irq;
  assign irq_lvl  = raw_pend && ie_q;
  assign irq      = irq_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ldval_q <= '0;
      ie_q    <= 1'b0;
      ovf_q   <= 1'b0;
      pin_q   <= '0;
    end else begin
      pin_q <= hw_pin;
      if (wr_hit(reg_we, reg_addr, A_CTRL))   ctrl_q  <= reg_wdata & CTRL_MASK;
      if (wr_hit(reg_we, reg_addr, A_LDVAL))  ldval_q <= reg_wdata;
      if (wr_hit(reg_we, reg_addr, A_IRQ_EN)) ie_q    <= reg_wdata[0];
      if (ovf_clr)             ovf_q <= 1'b0;
      if (q_drop || collide)   ovf_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_IDENT:    reg_rdata = ID_WORD;
      A_CTRL:     reg_rdata = ctrl_q;
      A_LDVAL:    reg_rdata = ldval_q;
      A_STAT_RAW: reg_rdata = {30'd0, ovf_q, raw_pend};
      A_STAT_MSK: reg_rdata = {31'd0, irq_lvl};
      A_IRQ_EN:   reg_rdata = {31'd0, ie_q};
      A_EV_TS:    reg_rdata = head_rec.stamp;
      A_EV_DESC:  reg_rdata = head_rec.desc;
      default:    reg_rdata = '0;
    endcase
  end

  // R10
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  // R12
  collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> ovf_q);
  // R2
  idle_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !win_vld);
  // R11
  pending_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_empty && ie_q) |-> irq);
  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> (head_rec == '0));
endmodule

// File: tb/test_ts_capture_unit.sv
module test_ts_capture_unit;
  localparam int          DEPTH = 4;
  localparam logic [31:0] IDW   = 32'h1234_5678;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  hw_pin = '0;
  logic        rx_stb = 1'b0, tx_stb = 1'b0;
  logic [4:0]  rx_port = '0, tx_port = '0;
  logic [3:0]  rx_msg = '0, tx_msg = '0;
  logic [15:0] rx_seq = '0, tx_seq = '0;
  logic        irq;

  always #4 clk = ~clk;   // 125 MHz

  ts_capture_unit #(.FIFO_DEPTH(DEPTH), .ID_WORD(IDW)) i_ts_capture_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_pin(hw_pin),
    .rx_stb(rx_stb), .rx_port(rx_port), .rx_msg(rx_msg), .rx_seq(rx_seq),
    .tx_stb(tx_stb), .tx_port(tx_port), .tx_msg(tx_msg), .tx_seq(tx_seq),
    .irq(irq)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cnt = 0, m_ctrl = 0, m_ld = 0;
  logic        m_ie = 0, m_ovf = 0;
  logic [3:0]  m_pin = 0;
  logic [63:0] m_q[$];
  logic [63:0] m_ev[$];

  function automatic logic [31:0] d(int port, int kind, int msg, int seq);
    return {3'b000, 5'(port), 4'(kind), 4'(msg), 16'(seq)};
  endfunction

  function automatic logic m_raw();
    return (m_q.size() != 0) || m_ctrl[1];
  endfunction

  function automatic logic [31:0] mrd(logic [5:0] a);
    case (a)
      6'h00: return IDW;
      6'h04: return m_ctrl;
      6'h10: return m_ld;
      6'h20: return {30'd0, m_ovf, m_raw()};
      6'h24: return {31'd0, m_raw() && m_ie};
      6'h28: return {31'd0, m_ie};
      6'h34: return (m_q.size() != 0) ? m_q[0][31:0] : 32'd0;
      6'h38: return (m_q.size() != 0) ? m_q[0][63:32] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    if (!rst_n) begin
      m_cnt = 0; m_ctrl = 0; m_ld = 0; m_ie = 0; m_ovf = 0; m_pin = 0;
      m_q.delete();
    end else begin
      logic run, ld;
      int   sz;
      m_ev.delete();
      run = m_ctrl[0];
      ld  = reg_we && reg_addr == 6'h14 && reg_wdata[0];
      if (run && !ld && m_cnt == 32'hFFFF_FFFF) m_ev.push_back({d(0, 1, 0, 0), 32'h0});
      if (run && !ld && m_cnt == 32'h7FFF_FFFF) m_ev.push_back({d(0, 2, 0, 0), 32'h8000_0000});
      for (int k = 0; k < 4; k++)
        if (run && hw_pin[k] && !m_pin[k] && m_ctrl[8+k]) m_ev.push_back({d(k + 1, 3, 0, 0), m_cnt});
      if (run && rx_stb) m_ev.push_back({d(rx_port, 4, rx_msg, rx_seq), m_cnt});
      if (run && tx_stb) m_ev.push_back({d(tx_port, 5, tx_msg, tx_seq), m_cnt});
      if (run && reg_we && reg_addr == 6'h0C && reg_wdata[0]) m_ev.push_back({d(0, 0, 0, 0), m_cnt});
      sz = m_q.size();
      if (reg_we && reg_addr == 6'h20 && reg_wdata[1]) m_ovf = 0;
      if (m_ev.size() > 1) m_ovf = 1;
      if (reg_we && reg_addr == 6'h30 && reg_wdata[0] && sz > 0) void'(m_q.pop_front());
      if (m_ev.size() > 0) begin
        if (sz < DEPTH) m_q.push_back(m_ev[0]);
        else m_ovf = 1;
      end
      if (ld) m_cnt = m_ld;
      else if (run) m_cnt = m_cnt + 1;
      if (reg_we && reg_addr == 6'h04) m_ctrl = reg_wdata & 32'h0000_0F03;
      if (reg_we && reg_addr == 6'h10) m_ld = reg_wdata;
      if (reg_we && reg_addr == 6'h28) m_ie = reg_wdata[0];
      m_pin = hw_pin;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(cur_req, "irq vs model", {31'd0, irq}, {31'd0, m_raw() && m_ie});
    check(cur_req, "rdata vs model", reg_rdata, mrd(reg_addr));
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] v);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic probe(logic [5:0] a, string tag, logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, "register read", reg_rdata, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog (R1): actual %0d cycles expected at most 20000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state, R13 identification
    cur_req = "R1";
    probe(6'h04, "R1", 0); probe(6'h10, "R1", 0); probe(6'h20, "R1", 0);
    probe(6'h24, "R1", 0); probe(6'h28, "R1", 0);
    probe(6'h34, "R1", 0); probe(6'h38, "R1", 0);
    check("R1", "irq", {31'd0, irq}, 0);
    probe(6'h00, "R13", IDW);

    // R3 load while idle, R2 push ignored while idle
    cur_req = "R3";
    wr(6'h10, 32'h100);
    probe(6'h10, "R3", 32'h100);
    wr(6'h14, 1);
    cur_req = "R2";
    wr(6'h0C, 1);
    probe(6'h20, "R2", 0);
    wr(6'h04, 1);

    // R4 push stamps current count, R8 layout, reading keeps record
    cur_req = "R4";
    wr(6'h0C, 1);
    probe(6'h34, "R4", 32'h100);
    probe(6'h38, "R8", 32'h0);
    probe(6'h34, "R8", 32'h100);
    cur_req = "R9";
    wr(6'h30, 1);
    probe(6'h34, "R9", 0);

    // R7 receive / transmit
    cur_req = "R7";
    rx_stb = 1; rx_port = 5; rx_msg = 3; rx_seq = 16'hBEEF;
    tick(); rx_stb = 0;
    probe(6'h38, "R7", 32'h0543_BEEF);
    wr(6'h30, 1);
    tx_stb = 1; tx_port = 2; tx_msg = 1; tx_seq = 16'h0007;
    tick(); tx_stb = 0;
    probe(6'h38, "R7", 32'h0251_0007);
    wr(6'h30, 1);

    // R6 pins
    cur_req = "R6";
    wr(6'h04, 32'h101);
    hw_pin = 4'b0010; tick(); hw_pin = 0; tick();
    probe(6'h20, "R6", 0);
    hw_pin = 4'b0001; tick(); tick(); tick(); hw_pin = 0; tick();
    probe(6'h38, "R6", 32'h0130_0000);
    wr(6'h30, 1);
    probe(6'h20, "R6", 0);

    // R5 wrap and half
    cur_req = "R5";
    wr(6'h10, 32'hFFFF_FFFD); wr(6'h14, 1);
    repeat (4) tick();
    probe(6'h38, "R5", 32'h0010_0000);
    probe(6'h34, "R5", 32'h0);
    wr(6'h30, 1);
    wr(6'h10, 32'h7FFF_FFFE); wr(6'h14, 1);
    repeat (4) tick();
    probe(6'h38, "R5", 32'h0020_0000);
    probe(6'h34, "R5", 32'h8000_0000);
    wr(6'h30, 1);
    probe(6'h20, "R5", 0);

    // R12 simultaneous sources
    cur_req = "R12";
    rx_stb = 1; rx_port = 1; rx_msg = 0; rx_seq = 1; tx_stb = 1;
    wr(6'h0C, 1);
    rx_stb = 0; tx_stb = 0;
    probe(6'h20, "R12", 32'h3);
    probe(6'h38, "R12", 32'h0140_0001);
    wr(6'h30, 1);
    wr(6'h20, 2);
    probe(6'h20, "R12", 0);

    // R10 overflow, R9 order and pop on empty
    cur_req = "R10";
    for (int i = 0; i < DEPTH + 1; i++) wr(6'h0C, 1);
    probe(6'h20, "R10", 32'h3);
    cur_req = "R9";
    for (int i = 0; i < DEPTH; i++) wr(6'h30, 1);
    probe(6'h20, "R10", 32'h2);
    wr(6'h30, 1);
    probe(6'h34, "R9", 0); probe(6'h38, "R9", 0);
    cur_req = "R10";
    wr(6'h20, 2);
    probe(6'h20, "R10", 0);

    // R11 interrupt
    cur_req = "R11";
    wr(6'h28, 1); wr(6'h04, 32'h3);
    check("R11", "irq with test bit", {31'd0, irq}, 1);
    probe(6'h24, "R11", 1);
    wr(6'h04, 1);
    check("R11", "irq cleared", {31'd0, irq}, 0);
    wr(6'h0C, 1);
    check("R11", "irq on pending", {31'd0, irq}, 1);
    wr(6'h28, 0);
    check("R11", "irq masked", {31'd0, irq}, 0);
    probe(6'h20, "R11", 1); probe(6'h24, "R11", 0);
    wr(6'h30, 1);

    // R13 control readback
    cur_req = "R13";
    wr(6'h04, 32'hFFFF_FFFF);
    probe(6'h04, "R13", 32'h0000_0F03);
    probe(6'h3C, "R13", 0);
    wr(6'h04, 0);

    // R2 idle ignores strobes
    cur_req = "R2";
    rx_stb = 1; tick(); rx_stb = 0; tick();
    probe(6'h20, "R2", 0);

    summary();
    $finish;
  end
endmodule